// File: doc/BRIEF.md
# ADC Result Capture Sequencer

This block moves 12-bit conversion results from a successive-approximation converter into external data RAM with no processor involvement. Software loads a 24-bit start pointer and arms the capture while the converter is powered down. It then picks a non-zero operating mode, and the sequencer runs a fixed loop on its own. It fetches a descriptor byte from RAM, starts one conversion on the channel that byte names, stores the result as two bytes in place of the descriptor, and moves the pointer on by two.

A descriptor whose channel nibble is all ones is an end marker. When the sequencer meets one it stops, drops the capture enable and raises a done flag, which is also driven on an interrupt pin. The register file also holds the converter's clock, acquisition and trigger settings and the calibration gain and offset words. These are stored and read back only.

Top module: `adc_ram_capture`

## Requirements
- R1: After reset, register 0 (control A) reads 0x20, register 1 (control B) reads 0x00, and pointer bytes 2..4, gain bytes 5..6 and offset bytes 7..8 read 0x00. `done_irq`, `ram_we`, `ram_re` and `conv_start` are low.
- R2: Control A is fully read/write. Bits [7:6] are the mode (00 = converter powered down), [5:4] the clock divider, [3:2] the acquisition time, [1] the timer trigger enable and [0] the external trigger enable.
- R3: In control B, bit [7] is the done flag, [6] the capture enable, [5] continuous conversion, [4] single conversion and [3:0] the channel. Bits [7], [5:0] store whatever software writes.
- R4: A write of 1 to the capture enable sets it only if the mode reads 00 at the time of the write, or if the enable is already 1. Otherwise the enable stays 0 and the other control B bits are still written.
- R5: Pointer bytes 2, 3 and 4 hold bits [7:0], [15:8] and [23:16] of the pointer and always read the live pointer. Writes to them are ignored while the capture enable is 1.
- R6: The sequencer fetches only while the capture enable is 1 and the mode is non-zero. A fetch asserts `ram_re` for one cycle at the pointer, and the RAM returns the byte on the next cycle. The channel ID is the upper nibble [7:4] of that byte.
- R7: For an ID other than 0xF, the sequencer gives exactly one one-cycle `conv_start` pulse. After `conv_valid`, it writes {ID, result[11:8]} at the pointer and then result[7:0] at pointer+1, on two consecutive cycles.
- R8: After the second byte is written, the pointer advances by 2. The next fetch reads the new pointer, so the results of a run lie contiguously in memory.
- R9: An ID of 0xF starts no conversion and writes nothing. It clears the capture enable, sets the done flag and leaves the pointer on the marker. `done_irq` equals the done flag.
- R10: If a control B write falls in the same cycle as an end marker, the hardware wins. The done flag ends at 1 and the capture enable at 0, and the rest of the written value is taken.
- R11: The gain word is 8 low bits at byte 5 and 6 high bits at byte 6. The offset word has the same split at bytes 7 and 8. The upper two bits of bytes 6 and 8 read 0.
- R12: In a running capture, the next `conv_start` comes exactly 4 cycles after the cycle in which `conv_valid` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_valid | input | 1 | Conversion result valid |
| conv_result | input | 12 | Conversion result, straight binary |
| ram_addr | output | 24 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe (data one cycle later) |
| ram_rdata | input | 8 | RAM read data |
| done_irq | output | 1 | Done flag |

## Verification
The hardware end-of-capture update and a software write to control B can land on the same cycle, and both touch the done flag and the capture enable. The bench places an end marker in RAM and watches `ram_re` to find the fetch of that marker. It then issues a control B write of 0x00 on the very next cycle, when the marker byte is being judged. Reading control B back must give 0x80: flag set, enable clear, channel and mode bits taken from the write.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned RES_W   = 12;
  localparam int unsigned ID_W    = 4;
  localparam int unsigned RADDR_W = 4;

  localparam logic [ID_W-1:0]    STOP_ID   = 4'hF;
  localparam logic [BYTE_W-1:0]  CTRLA_RST = 8'h20;
  localparam logic [RADDR_W-1:0] A_CTRLA   = 4'd0;
  localparam logic [RADDR_W-1:0] A_CTRLB   = 4'd1;
  localparam logic [RADDR_W-1:0] A_PTR0    = 4'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_WAIT, S_WR_HI, S_WR_LO
  } seq_state_t;

  function automatic logic [ID_W-1:0] desc_id(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1 -: ID_W];
  endfunction

  function automatic logic is_stop(input logic [BYTE_W-1:0] b);
    return desc_id(b) == STOP_ID;
  endfunction

  function automatic logic [BYTE_W-1:0] pack_hi(input logic [ID_W-1:0] id,
                                                input logic [RES_W-1:0] r);
    return {id, r[RES_W-1 -: (BYTE_W-ID_W)]};
  endfunction

  function automatic logic [BYTE_W-1:0] pack_lo(input logic [RES_W-1:0] r);
    return r[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/adc_cap_regs.sv
module adc_cap_regs
  import adc_cap_pkg::*;
#(
  parameter int unsigned PTR_BYTES = 3,
  parameter int unsigned CAL_HI_W  = 6,
  localparam int unsigned ADDR_W   = BYTE_W * PTR_BYTES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [RADDR_W-1:0]  addr,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [BYTE_W-1:0]   rdata,
  input  logic                ptr_step,
  input  logic                end_hit,
  output logic [1:0]          mode,
  output logic                dma_en,
  output logic                done_flag,
  output logic [ADDR_W-1:0]   ptr
);
  localparam logic [RADDR_W-1:0] A_GLO = RADDR_W'(A_PTR0 + PTR_BYTES);
  localparam logic [RADDR_W-1:0] A_GHI = RADDR_W'(A_PTR0 + PTR_BYTES + 1);
  localparam logic [RADDR_W-1:0] A_OLO = RADDR_W'(A_PTR0 + PTR_BYTES + 2);
  localparam logic [RADDR_W-1:0] A_OHI = RADDR_W'(A_PTR0 + PTR_BYTES + 3);

  logic [BYTE_W-1:0]   ctrla_q;
  logic                flag_q, dma_q, cont_q, single_q;
  logic [ID_W-1:0]     chan_q;
  logic [ADDR_W-1:0]   ptr_q, ptr_nx;
  logic [BYTE_W-1:0]   gain_lo_q, ofs_lo_q;
  logic [CAL_HI_W-1:0] gain_hi_q, ofs_hi_q;
  logic                flag_nx, dma_nx;
  logic [PTR_BYTES-1:0] lane_sel;

  wire ctrlb_wr = wr_en && (addr == A_CTRLB);

  // one write lane per pointer byte, locked while capture is enabled
  for (genvar i = 0; i < PTR_BYTES; i++) begin : g_lane
    assign lane_sel[i] = wr_en && !dma_q && (addr == RADDR_W'(A_PTR0 + i));
  end

  always_comb begin
    ptr_nx = ptr_q;
    for (int i = 0; i < PTR_BYTES; i++) begin
      if (lane_sel[i]) ptr_nx[i*BYTE_W +: BYTE_W] = wdata;
    end
    if (ptr_step) ptr_nx = ptr_q + ADDR_W'(2);
  end

  // hardware end-of-capture update takes priority over software
  always_comb begin
    flag_nx = flag_q;
    dma_nx  = dma_q;
    if (ctrlb_wr) begin
      flag_nx = wdata[7];
      dma_nx  = wdata[6] && (dma_q || (ctrla_q[7:6] == 2'b00));
    end
    if (end_hit) begin
      flag_nx = 1'b1;
      dma_nx  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrla_q   <= CTRLA_RST;
      flag_q    <= 1'b0;
      dma_q     <= 1'b0;
      cont_q    <= 1'b0;
      single_q  <= 1'b0;
      chan_q    <= '0;
      ptr_q     <= '0;
      gain_lo_q <= '0;
      gain_hi_q <= '0;
      ofs_lo_q  <= '0;
      ofs_hi_q  <= '0;
    end else begin
      flag_q <= flag_nx;
      dma_q  <= dma_nx;
      ptr_q  <= ptr_nx;
      if (wr_en && addr == A_CTRLA) ctrla_q <= wdata;
      if (ctrlb_wr) begin
        cont_q   <= wdata[5];
        single_q <= wdata[4];
        chan_q   <= wdata[3:0];
      end
      if (wr_en && addr == A_GLO) gain_lo_q <= wdata;
      if (wr_en && addr == A_GHI) gain_hi_q <= wdata[CAL_HI_W-1:0];
      if (wr_en && addr == A_OLO) ofs_lo_q  <= wdata;
      if (wr_en && addr == A_OHI) ofs_hi_q  <= wdata[CAL_HI_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CTRLA) rdata = ctrla_q;
    if (addr == A_CTRLB) rdata = {flag_q, dma_q, cont_q, single_q, chan_q};
    for (int i = 0; i < PTR_BYTES; i++) begin
      if (addr == RADDR_W'(A_PTR0 + i)) rdata = ptr_q[i*BYTE_W +: BYTE_W];
    end
    if (addr == A_GLO) rdata = gain_lo_q;
    if (addr == A_GHI) rdata = BYTE_W'(gain_hi_q);
    if (addr == A_OLO) rdata = ofs_lo_q;
    if (addr == A_OHI) rdata = BYTE_W'(ofs_hi_q);
  end

  assign mode      = ctrla_q[7:6];
  assign dma_en    = dma_q;
  assign done_flag = flag_q;
  assign ptr       = ptr_q;
endmodule

// File: rtl/adc_cap_seq.sv
module adc_cap_seq
  import adc_cap_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [BYTE_W-1:0] ram_rdata,
  input  logic              conv_valid,
  input  logic [RES_W-1:0]  conv_result,
  output logic              conv_start,
  output logic              ram_re,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic              ptr_step,
  output logic              end_hit
);
  seq_state_t       state_q, state_nx;
  logic [ID_W-1:0]  chan_q;
  logic [RES_W-1:0] res_q;

  always_comb begin
    state_nx   = state_q;
    conv_start = 1'b0;
    ram_re     = 1'b0;
    ram_we     = 1'b0;
    ram_addr   = ptr;
    ram_wdata  = '0;
    ptr_step   = 1'b0;
    end_hit    = 1'b0;
    unique case (state_q)
      S_IDLE:  if (run) state_nx = S_FETCH;
      S_FETCH: begin
        ram_re   = 1'b1;
        state_nx = S_CHECK;
      end
      S_CHECK: begin
        if (is_stop(ram_rdata)) begin
          end_hit  = 1'b1;
          state_nx = S_IDLE;
        end else begin
          conv_start = 1'b1;
          state_nx   = S_WAIT;
        end
      end
      S_WAIT:  if (conv_valid) state_nx = S_WR_HI;
      S_WR_HI: begin
        ram_we    = 1'b1;
        ram_wdata = pack_hi(chan_q, res_q);
        state_nx  = S_WR_LO;
      end
      S_WR_LO: begin
        ram_we    = 1'b1;
        ram_addr  = ptr + ADDR_W'(1);
        ram_wdata = pack_lo(res_q);
        ptr_step  = 1'b1;
        state_nx  = run ? S_FETCH : S_IDLE;
      end
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      chan_q  <= '0;
      res_q   <= '0;
    end else begin
      state_q <= state_nx;
      if (state_q == S_CHECK) chan_q <= desc_id(ram_rdata);
      if (state_q == S_WAIT && conv_valid) res_q <= conv_result;
    end
  end
endmodule

// File: rtl/adc_ram_capture.sv
module adc_ram_capture
  import adc_cap_pkg::*;
#(
  parameter int unsigned PTR_BYTES = 3,
  parameter int unsigned CAL_HI_W  = 6,
  localparam int unsigned ADDR_W   = BYTE_W * PTR_BYTES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0]  reg_wdata,
  output logic [BYTE_W-1:0]  reg_rdata,
  output logic               conv_start,
  input  logic               conv_valid,
  input  logic [RES_W-1:0]   conv_result,
  output logic [ADDR_W-1:0]  ram_addr,
  output logic [BYTE_W-1:0]  ram_wdata,
  output logic               ram_we,
  output logic               ram_re,
  input  logic [BYTE_W-1:0]  ram_rdata,
  output logic               done_irq
);
  // named internal events, observed by the bound checker
  logic [1:0]        mode_q;
  logic              dma_en;
  logic              done_flag;
  logic [ADDR_W-1:0] ptr_q;
  logic              evt_step;
  logic              evt_end;

  wire run = dma_en && (mode_q != 2'b00);

  adc_cap_regs #(.PTR_BYTES(PTR_BYTES), .CAL_HI_W(CAL_HI_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .ptr_step (evt_step),
    .end_hit  (evt_end),
    .mode     (mode_q),
    .dma_en   (dma_en),
    .done_flag(done_flag),
    .ptr      (ptr_q)
  );

  adc_cap_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .ptr        (ptr_q),
    .ram_rdata  (ram_rdata),
    .conv_valid (conv_valid),
    .conv_result(conv_result),
    .conv_start (conv_start),
    .ram_re     (ram_re),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .ptr_step   (evt_step),
    .end_hit    (evt_end)
  );

  assign done_irq = done_flag;
endmodule

// File: rtl/adc_ram_capture_chk.sv
module adc_ram_capture_chk #(
  parameter int unsigned ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [3:0]        reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              conv_start,
  input logic              ram_we,
  input logic              ram_re,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [1:0]        mode_q,
  input logic              dma_en,
  input logic              done_flag,
  input logic [ADDR_W-1:0] ptr_q,
  input logic              evt_step,
  input logic              evt_end
);
  assert_arm_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'd1 && reg_wdata[6] && !dma_en && mode_q != 2'b00)
      |=> !dma_en);

  assert_ptr_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && !evt_step) |=> (ptr_q == $past(ptr_q)));

  assert_re_we_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_re && ram_we));

  assert_start_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_hi_then_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !evt_step) |=> (ram_we && evt_step && ram_addr == $past(ram_addr) + ADDR_W'(1)));

  assert_step_by_two_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_step |=> (ptr_q == $past(ptr_q) + ADDR_W'(2)));

  assert_end_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_end |=> (!dma_en && done_flag));
endmodule

bind adc_ram_capture adc_ram_capture_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .conv_start(conv_start),
  .ram_we    (ram_we),
  .ram_re    (ram_re),
  .ram_addr  (ram_addr),
  .mode_q    (mode_q),
  .dma_en    (dma_en),
  .done_flag (done_flag),
  .ptr_q     (ptr_q),
  .evt_step  (evt_step),
  .evt_end   (evt_end)
);

// File: tb/adc_ram_capture_bench.sv
module adc_ram_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        conv_start;
  logic        conv_valid;
  logic [11:0] conv_result;
  logic [23:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic        ram_we;
  logic        ram_re;
  logic [7:0]  ram_rdata;
  logic        done_irq;

  always #10 clk = ~clk;

  adc_ram_capture u_adc_ram_capture (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_start(conv_start),
    .conv_valid(conv_valid), .conv_result(conv_result), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_re(ram_re),
    .ram_rdata(ram_rdata), .done_irq(done_irq)
  );

  int n_chk = 0;
  int n_fail = 0;

  // RAM model: 256 bytes on the low address bits, one-cycle read
  logic [7:0] mem [0:255];
  logic       poke_en = 1'b0;
  logic [7:0] poke_a = '0;
  logic [7:0] poke_d = '0;
  logic [15:0] hi_seen;
  always @(posedge clk) begin
    if (poke_en) mem[poke_a] <= poke_d;
    if (ram_we) begin
      mem[ram_addr[7:0]] <= ram_wdata;
      hi_seen <= ram_addr[23:8];
    end
    if (ram_re) ram_rdata <= mem[ram_addr[7:0]];
  end

  // converter model: result valid 3 cycles after the start pulse
  logic [2:0] sr;
  int k = 0;
  always @(posedge clk) begin
    if (!rst_n) sr <= '0;
    else sr <= {sr[1:0], conv_start};
    if (conv_valid) k <= k + 1;
  end
  assign conv_valid  = sr[2];
  assign conv_result = 12'h5A3 + 12'(k * 32'h111);

  // event monitors
  int cyc = 0, valid_cyc = 0, n_start = 0, n_re = 0, n_gap = 0, gap_bad = 0;
  logic have_v = 1'b0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ram_re) n_re <= n_re + 1;
    if (conv_valid) begin
      valid_cyc <= cyc;
      have_v <= 1'b1;
    end else if (conv_start) begin
      n_start <= n_start + 1;
      have_v <= 1'b0;
      if (have_v) begin
        n_gap <= n_gap + 1;
        if (cyc - valid_cyc != 4) gap_bad <= gap_bad + 1;
      end
    end else if (done_irq) have_v <= 1'b0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_a = a; poke_d = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (done_irq) begin ok = 1'b1; break; end
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd_reg(4'd0, v); chk("R1 ctrlA reset", v, 8'h20);
    rd_reg(4'd1, v); chk("R1 ctrlB reset", v, 8'h00);
    for (int a = 2; a <= 8; a++) begin
      rd_reg(4'(a), v); chk("R1 data reg reset", v, 8'h00);
    end
    chk("R1 outputs idle", {done_irq, ram_we, ram_re, conv_start}, 4'b0000);
  endtask

  task automatic t_fields();
    logic [7:0] v;
    wr_reg(4'd0, 8'hDB); rd_reg(4'd0, v); chk("R2 ctrlA fields", v, 8'hDB);
    wr_reg(4'd0, 8'h24); rd_reg(4'd0, v); chk("R2 ctrlA rewrite", v, 8'h24);
    wr_reg(4'd1, 8'hBA); rd_reg(4'd1, v); chk("R3 ctrlB fields", v, 8'hBA);
    wr_reg(4'd1, 8'h00);
    wr_reg(4'd5, 8'hA5); rd_reg(4'd5, v); chk("R11 gain low", v, 8'hA5);
    wr_reg(4'd6, 8'hFF); rd_reg(4'd6, v); chk("R11 gain high 6 bits", v, 8'h3F);
    wr_reg(4'd7, 8'h5C); rd_reg(4'd7, v); chk("R11 offset low", v, 8'h5C);
    wr_reg(4'd8, 8'hEA); rd_reg(4'd8, v); chk("R11 offset high 6 bits", v, 8'h2A);
  endtask

  task automatic t_arm_refused();
    logic [7:0] v;
    int s0;
    s0 = n_start;
    wr_reg(4'd0, 8'h60);
    wr_reg(4'd1, 8'h45);
    rd_reg(4'd1, v); chk("R4 arm refused in active mode", v, 8'h05);
    repeat (20) @(negedge clk);
    chk("R6 no conversion when disabled", n_start - s0, 0);
    wr_reg(4'd1, 8'h00);
    wr_reg(4'd0, 8'h20);
  endtask

  task automatic t_capture();
    logic [7:0] v;
    logic [11:0] r;
    logic [3:0] ids [3];
    bit ok;
    int k0, s0, re0, g0, gb0;
    ids[0] = 4'h3; ids[1] = 4'h7; ids[2] = 4'h0;
    for (int i = 0; i < 3; i++) begin
      poke(8'(8'h10 + 2*i), {ids[i], 4'h9});
      poke(8'(8'h11 + 2*i), 8'h77);
    end
    poke(8'h16, 8'hF0);
    poke(8'h17, 8'hEE);
    wr_reg(4'd2, 8'h10); wr_reg(4'd3, 8'h00); wr_reg(4'd4, 8'hAB);
    rd_reg(4'd4, v); chk("R5 pointer high byte", v, 8'hAB);
    wr_reg(4'd1, 8'h40);
    rd_reg(4'd1, v); chk("R4 arm accepted in mode 00", v, 8'h40);
    wr_reg(4'd2, 8'h50);
    rd_reg(4'd2, v); chk("R5 pointer write ignored while armed", v, 8'h10);
    re0 = n_re;
    repeat (10) @(negedge clk);
    chk("R6 no fetch in mode 00", n_re - re0, 0);
    k0 = k; s0 = n_start; g0 = n_gap; gb0 = gap_bad;
    wr_reg(4'd0, 8'h60);
    wait_done(ok);
    chk("R9 capture finished", 32'(ok), 1);
    for (int i = 0; i < 3; i++) begin
      r = 12'h5A3 + 12'((k0 + i) * 32'h111);
      chk("R7 first byte id and high result", mem[8'h10 + 2*i], {ids[i], r[11:8]});
      chk("R7 second byte low result", mem[8'h11 + 2*i], r[7:0]);
    end
    chk("R7 one start per descriptor", n_start - s0, 3);
    chk("R8 upper address bits", hi_seen, 16'hAB00);
    chk("R9 marker byte untouched", mem[8'h16], 8'hF0);
    chk("R9 byte after marker untouched", mem[8'h17], 8'hEE);
    rd_reg(4'd2, v); chk("R8 pointer stops on marker", v, 8'h16);
    rd_reg(4'd4, v); chk("R8 pointer high kept", v, 8'hAB);
    rd_reg(4'd1, v); chk("R9 flag set enable cleared", v, 8'h80);
    chk("R9 irq follows flag", 32'(done_irq), 1);
    chk("R12 gaps measured", n_gap - g0, 2);
    chk("R12 start four cycles after valid", gap_bad - gb0, 0);
  endtask

  task automatic t_same_cycle();
    logic [7:0] v;
    bit hit;
    wr_reg(4'd0, 8'h20);
    wr_reg(4'd1, 8'h00);
    chk("R9 irq cleared by software", 32'(done_irq), 0);
    poke(8'h20, 8'h1C);
    poke(8'h22, 8'hF5);
    wr_reg(4'd2, 8'h20); wr_reg(4'd3, 8'h00); wr_reg(4'd4, 8'h00);
    wr_reg(4'd1, 8'h40);
    wr_reg(4'd0, 8'h60);
    hit = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (ram_re && ram_addr[7:0] == 8'h22) begin hit = 1'b1; break; end
    end
    chk("R10 marker fetch seen", 32'(hit), 1);
    wr_reg(4'd1, 8'h00);
    rd_reg(4'd1, v); chk("R10 hardware wins same-cycle write", v, 8'h80);
    rd_reg(4'd2, v); chk("R10 pointer on marker", v, 8'h22);
    chk("R10 irq high", 32'(done_irq), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    fork
      begin
        t_reset();
        t_fields();
        t_arm_refused();
        t_capture();
        t_same_cycle();
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule